// File: doc/BRIEF.md
# USART Control Word Sequencer

This block is the processor-side register front end of a programmable serial port. A processor reaches it through chip select, read and write strobes and a select line that chooses the data path or the control/status path. Control writes do not all mean the same thing. After any reset, the first control write configures the line format. When that format is synchronous, one or two further writes then load the sync characters. Only after that are control writes taken as commands. A command drives the modem handshake outputs, the transmit and receive enables, the forced break and two housekeeping actions: clearing the error flags and running an internal reset.

Data writes fill a one-entry transmit holding register. That register feeds the transmitter over a valid/ready stream. `tx_valid` stays high, with `tx_data` held stable, until the transmitter raises `tx_ready` at a clock edge. A data write that arrives while the register is full is dropped. The receiver offers a character on `rx_valid`/`rx_data`. A data read from the processor returns that character, and `rx_ready` pulses to take it. Status reads combine the holding-register state, the receiver's character-ready state, three latched error flags, the sync-detect input and the data-set-ready input.

The processor bus is split into `din` and `dout` plus a drive enable `dout_oe`, so that the block stays free of tri-states. Serial shifting and baud generation sit outside this block.

Top module: `usart_ctl_seq`

## Requirements
- R1: While `rst` is high, and after it falls, the sequencer waits for a mode word: `cmd_ready` is 0, `dtr_n` and `rts_n` are 1, and `tx_en`, `rx_en`, `brk` and `tx_valid` are 0.
- R2: Mode word fields are decoded as follows. Bits [1:0] select the baud factor: 00 = synchronous, 01 = x1, 10 = x16, 11 = x64, shown on `baud_sel`. Bits [3:2] give the character length, shown on `char_bits` as 5 plus the field value. Bit 4 enables parity and bit 5 selects even parity. In asynchronous modes bits [7:6] appear on `stop_code`. In synchronous mode bit 6 appears on `ext_sync` and bit 7 on `single_sync`. The fields that do not apply to the chosen mode read as 0.
- R3: After a synchronous mode word, the next control write loads `sync_char1`. If bit 7 of the mode word is 0, the write after that loads `sync_char2`. `cmd_ready` rises only once the last sync character has been loaded.
- R4: After an asynchronous mode word, `cmd_ready` is 1 from the next cycle on.
- R5: Every control write made while `cmd_ready` is 1 replaces the whole command. The command bits drive the outputs as follows: bit 0 sets `tx_en`, bit 1 drives `dtr_n` low, bit 2 sets `rx_en`, bit 3 sets `brk`, and bit 5 drives `rts_n` low.
- R6: A command with bit 6 set acts exactly like the reset pin: the sequencer returns to waiting for a mode word, and the other bits of that word have no effect.
- R7: The error flags latch on one-cycle pulses: parity on `pe_set`, overrun on `oe_set`, framing on `fe_set`. A command with bit 4 set clears them. A pulse in the same cycle as a clear wins.
- R8: A control-path read places the status word on `dout`. Bit 0 is holding register empty. Bit 1 is `rx_valid`. Bit 2 is holding register empty and `tx_idle`. Bits 3, 4 and 5 are the parity, overrun and framing flags. Bit 6 is `syndet`. Bit 7 is the inverse of `dsr_n`.
- R9: An access happens only on the first clock of a strobe-low period with `cs_n` low. A strobe held low for several cycles counts once. A strobe with `cs_n` high is ignored.
- R10: A data write loads the holding register only when it is empty. `tx_valid` and `tx_data` then hold steady until a clock edge on which `tx_ready` is high.
- R11: `dout_oe` is high exactly while `cs_n` and `rd_n` are both low. A data-path read returns `rx_data`. It also raises `rx_ready` for one cycle if `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_ctl | input | 1 | 1 = control/status path, 0 = data path |
| din | input | 8 | Write data from processor |
| dout | output | 8 | Read data to processor |
| dout_oe | output | 1 | Read data drive enable |
| tx_data | output | 8 | Character to transmitter |
| tx_valid | output | 1 | Holding register full |
| tx_ready | input | 1 | Transmitter takes the character |
| rx_data | input | 8 | Character from receiver |
| rx_valid | input | 1 | Receiver holds a character |
| rx_ready | output | 1 | Character taken by processor read |
| tx_idle | input | 1 | Transmitter shift register empty |
| syndet | input | 1 | Sync detect from receiver |
| dsr_n | input | 1 | Data set ready, active low |
| pe_set | input | 1 | Parity error pulse |
| oe_set | input | 1 | Overrun error pulse |
| fe_set | input | 1 | Framing error pulse |
| cmd_ready | output | 1 | Sequencer accepts commands |
| baud_sel | output | 2 | Baud factor code |
| char_bits | output | 4 | Character length in bits |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity |
| stop_code | output | 2 | Stop bit code (asynchronous) |
| single_sync | output | 1 | One sync character (synchronous) |
| ext_sync | output | 1 | External sync detect (synchronous) |
| sync_char1 | output | 8 | First sync character |
| sync_char2 | output | 8 | Second sync character |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| brk | output | 1 | Force line low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
A sequencer stuck in or skipping a state shows within one cycle of the next control write. `cmd_ready`, the sync character outputs or the decoded mode fields then take the wrong values, because that write lands in the wrong register. A corrupted command register, or a missed internal reset, shows at once on the modem outputs and the enables. Wrong flag or holding-register state appears in the status word of the next read, and as a stream handshake that stalls or repeats on the following edge. The reference model is compared against every one of these outputs on every clock, so any divergence is reported in the cycle it occurs.

// File: rtl/usart_seq_pkg.sv
package usart_seq_pkg;
  localparam int DW = 8;
  localparam int NERR = 3;

  typedef enum logic [1:0] {
    S_MODE  = 2'd0,
    S_SYNC1 = 2'd1,
    S_SYNC2 = 2'd2,
    S_CMD   = 2'd3
  } seq_t;

  // command bit positions
  localparam int CB_TXEN = 0;
  localparam int CB_DTR  = 1;
  localparam int CB_RXEN = 2;
  localparam int CB_BRK  = 3;
  localparam int CB_ERST = 4;
  localparam int CB_RTS  = 5;
  localparam int CB_IRST = 6;

  // mode word fields
  localparam int MB_BAUD_LO = 0;
  localparam int MB_LEN_LO  = 2;
  localparam int MB_PEN     = 4;
  localparam int MB_PEVEN   = 5;
  localparam int MB_EXT     = 6;
  localparam int MB_SINGLE  = 7;
endpackage

// File: rtl/usart_bus_acc.sv
module usart_bus_acc (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic sel_ctl,
  output logic ctl_wr,
  output logic dat_wr,
  output logic dat_rd,
  output logic rd_lvl
);
  logic wr_lvl, wr_q, rd_q, wr_edge, rd_edge;

  assign wr_lvl  = !cs_n && !wr_n;
  assign rd_lvl  = !cs_n && !rd_n;
  assign wr_edge = wr_lvl && !wr_q;
  assign rd_edge = rd_lvl && !rd_q;
  assign ctl_wr  = wr_edge && sel_ctl;
  assign dat_wr  = wr_edge && !sel_ctl;
  assign dat_rd  = rd_edge && !sel_ctl;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_lvl;
      rd_q <= rd_lvl;
    end
  end

  p_single_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_edge |=> !wr_edge);
endmodule

// File: rtl/usart_seq_ctl.sv
module usart_seq_ctl
  import usart_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [DW-1:0] din,
  output logic          in_cmd,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] sync1_q,
  output logic [DW-1:0] sync2_q,
  output logic [DW-1:0] cmd_q,
  output logic          soft_rst,
  output logic          err_clr
);
  seq_t st;
  logic sync_mode_in;

  assign in_cmd       = (st == S_CMD);
  assign sync_mode_in = (din[MB_BAUD_LO+1:MB_BAUD_LO] == 2'b00);
  assign soft_rst     = ctl_wr && in_cmd && din[CB_IRST];
  assign err_clr      = ctl_wr && in_cmd && din[CB_ERST] && !din[CB_IRST];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st      <= S_MODE;
      mode_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      cmd_q   <= '0;
    end else if (ctl_wr) begin
      unique case (st)
        S_MODE: begin
          mode_q <= din;
          st     <= sync_mode_in ? S_SYNC1 : S_CMD;
        end
        S_SYNC1: begin
          sync1_q <= din;
          st      <= mode_q[MB_SINGLE] ? S_CMD : S_SYNC2;
        end
        S_SYNC2: begin
          sync2_q <= din;
          st      <= S_CMD;
        end
        S_CMD: begin
          if (din[CB_IRST]) begin
            st      <= S_MODE;
            mode_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
            cmd_q   <= '0;
          end else begin
            cmd_q <= din;
          end
        end
        default: st <= S_MODE;
      endcase
    end
  end

  p_async_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && st == S_MODE && !sync_mode_in) |=> (st == S_CMD));
  p_sync_first_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && st == S_MODE && sync_mode_in) |=> (st == S_SYNC1));
  p_intrst_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && st == S_CMD && din[CB_IRST]) |=> (st == S_MODE && cmd_q == '0));
endmodule

// File: rtl/usart_stat.sv
module usart_stat
  import usart_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          err_clr,
  input  logic          dat_wr,
  input  logic [DW-1:0] din,
  input  logic          tx_ready,
  input  logic          tx_idle,
  input  logic          rx_valid,
  input  logic          syndet,
  input  logic          dsr_n,
  input  logic [NERR-1:0] err_set,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic [DW-1:0] status
);
  logic [NERR-1:0] err_q;
  logic            full_q;
  logic [DW-1:0]   hold_q;

  for (genvar i = 0; i < NERR; i++) begin : g_err
    always_ff @(posedge clk or posedge rst) begin
      if (rst)             err_q[i] <= 1'b0;
      else if (soft_rst)   err_q[i] <= 1'b0;
      else if (err_set[i]) err_q[i] <= 1'b1;
      else if (err_clr)    err_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (soft_rst) begin
      full_q <= 1'b0;
    end else begin
      if (dat_wr && !full_q) begin
        full_q <= 1'b1;
        hold_q <= din;
      end else if (full_q && tx_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign tx_valid = full_q;
  assign tx_data  = hold_q;
  assign status   = {!dsr_n, syndet, err_q, !full_q && tx_idle, rx_valid, !full_q};

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (err_clr && err_set == '0) |=> (err_q == '0));
endmodule

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq
  import usart_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       sel_ctl,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_oe,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic       tx_idle,
  input  logic       syndet,
  input  logic       dsr_n,
  input  logic       pe_set,
  input  logic       oe_set,
  input  logic       fe_set,
  output logic       cmd_ready,
  output logic [1:0] baud_sel,
  output logic [3:0] char_bits,
  output logic       par_en,
  output logic       par_even,
  output logic [1:0] stop_code,
  output logic       single_sync,
  output logic       ext_sync,
  output logic [7:0] sync_char1,
  output logic [7:0] sync_char2,
  output logic       tx_en,
  output logic       rx_en,
  output logic       brk,
  output logic       dtr_n,
  output logic       rts_n
);
  logic ctl_wr, dat_wr, dat_rd, rd_lvl, soft_rst, err_clr, is_sync;
  logic [DW-1:0] mode_q, cmd_q, status;

  usart_bus_acc u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel_ctl(sel_ctl), .ctl_wr(ctl_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .rd_lvl(rd_lvl)
  );

  usart_seq_ctl u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .din(din), .in_cmd(cmd_ready),
    .mode_q(mode_q), .sync1_q(sync_char1), .sync2_q(sync_char2),
    .cmd_q(cmd_q), .soft_rst(soft_rst), .err_clr(err_clr)
  );

  usart_stat u_stat (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .err_clr(err_clr),
    .dat_wr(dat_wr), .din(din), .tx_ready(tx_ready), .tx_idle(tx_idle),
    .rx_valid(rx_valid), .syndet(syndet), .dsr_n(dsr_n),
    .err_set({fe_set, oe_set, pe_set}), .tx_data(tx_data),
    .tx_valid(tx_valid), .status(status)
  );

  assign is_sync     = (mode_q[MB_BAUD_LO+1:MB_BAUD_LO] == 2'b00);
  assign baud_sel    = mode_q[MB_BAUD_LO+1:MB_BAUD_LO];
  assign char_bits   = 4'd5 + {2'b00, mode_q[MB_LEN_LO+1:MB_LEN_LO]};
  assign par_en      = mode_q[MB_PEN];
  assign par_even    = mode_q[MB_PEVEN];
  assign stop_code   = is_sync ? 2'b00 : mode_q[MB_SINGLE:MB_EXT];
  assign single_sync = is_sync && mode_q[MB_SINGLE];
  assign ext_sync    = is_sync && mode_q[MB_EXT];

  assign tx_en = cmd_q[CB_TXEN];
  assign rx_en = cmd_q[CB_RXEN];
  assign brk   = cmd_q[CB_BRK];
  assign dtr_n = !cmd_q[CB_DTR];
  assign rts_n = !cmd_q[CB_RTS];

  assign dout_oe  = rd_lvl;
  assign dout     = sel_ctl ? status : rx_data;
  assign rx_ready = dat_rd && rx_valid;

  p_modem_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |-> (dtr_n && rts_n && !tx_en && !brk));
endmodule

// File: tb/test_usart_ctl_seq.sv
`timescale 1ns/1ps
module test_usart_ctl_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_ctl = 1'b0;
  logic [7:0] din = '0, rx_data = '0;
  logic tx_ready = 1'b0, rx_valid = 1'b0, tx_idle = 1'b1, syndet = 1'b0, dsr_n = 1'b1;
  logic pe_set = 1'b0, oe_set = 1'b0, fe_set = 1'b0;
  logic [7:0] dout, tx_data, sync_char1, sync_char2;
  logic dout_oe, tx_valid, rx_ready, cmd_ready, par_en, par_even, single_sync, ext_sync;
  logic tx_en, rx_en, brk, dtr_n, rts_n;
  logic [1:0] baud_sel, stop_code;
  logic [3:0] char_bits;

  int checks = 0, errors = 0, pops = 0;
  bit done = 0;

  // reference model state
  int m_st = 0;
  logic [7:0] m_mode = 0, m_s1 = 0, m_s2 = 0, m_cmd = 0, m_txd = 0;
  logic [2:0] m_err = 0;
  bit m_full = 0, m_wrq = 0, m_rdq = 0;
  bit we, cw, dw, irst, clr, oldfull;

  usart_ctl_seq i_usart_ctl_seq (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_cmd = 0; m_err = 0; m_full = 0;
  endtask

  always @(posedge clk) begin
    we = !cs_n && !wr_n && !m_wrq;
    m_wrq = !cs_n && !wr_n;
    m_rdq = !cs_n && !rd_n;
    cw = we && sel_ctl;
    dw = we && !sel_ctl;
    if (rst) begin
      model_reset();
      m_wrq = 0; m_rdq = 0;
    end else begin
      irst = cw && m_st == 3 && din[6];
      clr = cw && m_st == 3 && din[4] && !din[6];
      oldfull = m_full;
      if (dw && !oldfull) begin m_full = 1; m_txd = din; end
      else if (oldfull && tx_ready) m_full = 0;
      if (pe_set) m_err[0] = 1; else if (clr) m_err[0] = 0;
      if (oe_set) m_err[1] = 1; else if (clr) m_err[1] = 0;
      if (fe_set) m_err[2] = 1; else if (clr) m_err[2] = 0;
      if (cw) begin
        case (m_st)
          0: begin m_mode = din; m_st = (din[1:0] == 0) ? 1 : 3; end
          1: begin m_s1 = din; m_st = m_mode[7] ? 3 : 2; end
          2: begin m_s2 = din; m_st = 3; end
          default: if (!din[6]) m_cmd = din;
        endcase
      end
      if (irst) model_reset();
    end
  end

  // cycle-by-cycle comparison, one time unit after each edge
  always @(posedge clk) begin
    #1;
    chk("R5 tx_en", tx_en, m_cmd[0]);
    chk("R5 dtr_n", dtr_n, !m_cmd[1]);
    chk("R5 rx_en", rx_en, m_cmd[2]);
    chk("R5 brk", brk, m_cmd[3]);
    chk("R5 rts_n", rts_n, !m_cmd[5]);
    chk("R3 cmd_ready", cmd_ready, m_st == 3);
    chk("R2 baud_sel", baud_sel, m_mode[1:0]);
    chk("R2 char_bits", char_bits, 5 + m_mode[3:2]);
    chk("R2 par_en", par_en, m_mode[4]);
    chk("R2 par_even", par_even, m_mode[5]);
    chk("R2 stop_code", stop_code, (m_mode[1:0] == 0) ? 0 : m_mode[7:6]);
    chk("R2 single_sync", single_sync, (m_mode[1:0] == 0) && m_mode[7]);
    chk("R2 ext_sync", ext_sync, (m_mode[1:0] == 0) && m_mode[6]);
    chk("R3 sync_char1", sync_char1, m_s1);
    chk("R3 sync_char2", sync_char2, m_s2);
    chk("R10 tx_valid", tx_valid, m_full);
    if (m_full) chk("R10 tx_data", tx_data, m_txd);
    chk("R11 dout_oe", dout_oe, !cs_n && !rd_n);
    if (!cs_n && !rd_n)
      chk("R8 dout", dout, sel_ctl ? {!dsr_n, syndet, m_err, !m_full && tx_idle, rx_valid, !m_full} : rx_data);
  end

  always @(negedge clk) begin
    #1;
    if (rx_ready) pops++;
  end

  task automatic bus_wr(input bit ctl, input logic [7:0] v, input int hold);
    @(negedge clk);
    cs_n = 0; wr_n = 0; sel_ctl = ctl; din = v;
    repeat (hold) @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_rd(input bit ctl, output logic [7:0] v);
    @(negedge clk);
    cs_n = 0; rd_n = 0; sel_ctl = ctl;
    #1 v = dout;
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic after();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 0;
    after();
    chk("R1 dtr_n after reset", dtr_n, 1);
    chk("R1 rts_n after reset", rts_n, 1);
    chk("R1 cmd_ready after reset", cmd_ready, 0);
    chk("R1 tx_valid after reset", tx_valid, 0);

    // async mode: x16, 8 bits, even parity, stop code 01
    bus_wr(1, 8'h7E, 1); after();
    chk("R4 cmd_ready after async mode", cmd_ready, 1);
    chk("R2 char_bits", char_bits, 8);
    chk("R2 stop_code", stop_code, 1);
    bus_wr(1, 8'h27, 1); after();
    chk("R5 dtr_n asserted", dtr_n, 0);
    chk("R5 rts_n asserted", rts_n, 0);

    // transmit stream with back-pressure
    bus_wr(0, 8'h55, 1);
    bus_wr(0, 8'hAA, 1); after();
    chk("R10 write while full ignored", tx_data, 8'h55);
    tx_ready = 1; @(negedge clk); tx_ready = 0; #1;
    chk("R10 drained", tx_valid, 0);

    // receive read
    rx_valid = 1; rx_data = 8'h3C;
    bus_rd(0, rv);
    chk("R11 data read value", rv, 8'h3C);
    after();
    chk("R11 one rx_ready pulse", pops, 1);
    rx_valid = 0;

    // error latching and clearing
    dsr_n = 0;
    @(negedge clk); pe_set = 1; oe_set = 1;
    @(negedge clk); pe_set = 0; oe_set = 0;
    bus_rd(1, rv);
    chk("R8 status with errors", rv, 8'h9D);
    bus_wr(1, 8'h37, 1);
    bus_rd(1, rv);
    chk("R7 status after clear", rv, 8'h85);

    // write with chip select high is ignored
    @(negedge clk); wr_n = 0; sel_ctl = 1; din = 8'h08;
    @(negedge clk); wr_n = 1; #1;
    chk("R9 cs_n high ignored", brk, 0);
    bus_wr(1, 8'h2F, 1); after();
    chk("R5 break", brk, 1);

    // internal reset
    bus_wr(1, 8'h67, 1); after();
    chk("R6 internal reset dtr_n", dtr_n, 1);
    chk("R6 internal reset cmd_ready", cmd_ready, 0);
    chk("R6 internal reset brk", brk, 0);

    // synchronous, two sync characters; mode written with a long strobe
    bus_wr(1, 8'h0C, 3); after();
    chk("R9 long strobe one write", cmd_ready, 0);
    chk("R9 sync1 untouched", sync_char1, 0);
    bus_wr(1, 8'h16, 1); after();
    chk("R3 after first sync", cmd_ready, 0);
    bus_wr(1, 8'h96, 1); after();
    chk("R3 after second sync", cmd_ready, 1);
    chk("R3 sync_char2", sync_char2, 8'h96);
    bus_wr(1, 8'h01, 1); after();
    chk("R5 tx_en", tx_en, 1);

    // pin reset, then single external sync
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    bus_wr(1, 8'hC4, 1); after();
    chk("R1 waits for sync after reset", cmd_ready, 0);
    chk("R2 single_sync", single_sync, 1);
    chk("R2 ext_sync", ext_sync, 1);
    chk("R2 char_bits 6", char_bits, 6);
    bus_wr(1, 8'hE7, 1); after();
    chk("R3 single sync done", cmd_ready, 1);
    chk("R3 sync_char1", sync_char1, 8'hE7);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule